// File: doc/BRIEF.md
# Prioritized Vectored Interrupt Controller

This block sits beside a small processor core and decides which interrupt the core takes and where the core must branch. It has five request inputs. One is a non-maskable line. Three are maskable lines, each with its own fixed vector. The last is a general maskable line whose vector comes from a restart opcode that the block reads off the data bus. Requests are only considered when the core signals that an instruction has finished. At that moment the block resolves all pending requests by a fixed priority. It then returns a vector address together with a request to push the program counter and an acknowledge.

Two layers of masking apply. A global enable flag gates every maskable line. The core sets this flag with an enable command and clears it with a disable command, and the block clears it by itself whenever it accepts a maskable interrupt. On top of that, each of the three fixed-vector lines has its own mask bit, loaded by a mask-write command. For the general line the block pulses an opcode-fetch request and waits for the byte on the bus. A restart opcode of the form 11NNN111 branches to N*8. Any other byte is flagged as an error, and no vector is issued for it.

Top module: `irq_vector_ctrl`

## Requirements
- R1: After reset, irq_ack, push_pc, opcode_fetch and bad_opcode are 0 and vec_addr is 0. The global enable is clear and all three mask bits are set, so only the non-maskable line can be taken.
- R2: When several lines are eligible at one boundary, exactly one is taken. The order from highest to lowest is: non-maskable line, fixed_req[2], fixed_req[1], fixed_req[0], general line.
- R3: The non-maskable line vectors to 0x0024. It is taken whatever the global enable and the mask bits hold.
- R4: fixed_req[0], fixed_req[1] and fixed_req[2] vector to 0x002C, 0x0034 and 0x003C respectively.
- R5: Taking the general line raises opcode_fetch for one cycle, and the block then waits for bus_valid. A byte of the form 11NNN111 (bits 7:6 = 11, bits 2:0 = 111) gives irq_ack, push_pc and vec_addr = N*8, with N taken from bits 5:3.
- R6: A byte on the general line that is not of the form 11NNN111 pulses bad_opcode for one cycle. irq_ack and push_pc stay low for it.
- R7: cmd_enable sets the global enable and cmd_disable clears it; if both come in the same cycle, the flag ends clear. While the flag is clear, no maskable line is taken.
- R8: cmd_mask_wr loads mask_data into the mask register. Bit i set to 1 blocks fixed_req[i]. The mask bits do not affect the general line or the non-maskable line.
- R9: A request is taken only in a cycle with insn_done high. While the block waits for an opcode, no request is taken, even at an instruction boundary.
- R10: irq_ack and push_pc rise together for exactly one cycle per taken interrupt. vec_addr holds the new vector in that cycle. At most one interrupt is taken per boundary.
- R11: Taking a fixed-vector line or the general line clears the global enable, and this clear wins over a same-cycle cmd_enable. Taking the non-maskable line leaves the global enable unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| insn_done | input | 1 | Current instruction has completed this cycle |
| trap_req | input | 1 | Non-maskable request |
| fixed_req | input | NUM_FIXED | Fixed-vector requests, index 0 lowest priority |
| gen_req | input | 1 | General maskable request |
| cmd_enable | input | 1 | Set the global enable |
| cmd_disable | input | 1 | Clear the global enable |
| cmd_mask_wr | input | 1 | Load mask_data into the mask register |
| mask_data | input | NUM_FIXED | Mask value, 1 blocks the line |
| bus_data | input | 8 | Opcode byte for the general line |
| bus_valid | input | 1 | bus_data holds the fetched opcode |
| irq_ack | output | 1 | Interrupt taken, one-cycle pulse |
| push_pc | output | 1 | Push the program counter, one-cycle pulse |
| vec_addr | output | ADDR_W | Branch target of the taken interrupt |
| opcode_fetch | output | 1 | Request to read the opcode for the general line |
| bad_opcode | output | 1 | Fetched byte was not a restart opcode |

## Verification
The bench uses the default parameters: three fixed lines, a 16-bit vector and a step of 8 for both vector families. With these values, all three fixed vectors, the non-maskable vector and the eight restart targets are distinct and can be checked as exact addresses. The directed scenarios cover the full priority ladder and the interaction of both mask layers. They also cover the automatic clear of the global enable, requests presented while an opcode fetch is pending, and both well-formed and near-miss opcode bytes.

// File: rtl/irqv_pkg.sv
package irqv_pkg;
  localparam int OPC_W  = 8;
  localparam int SLOT_W = 3;

  typedef enum logic [0:0] {
    ST_IDLE  = 1'b0,
    ST_FETCH = 1'b1
  } irqv_state_e;
endpackage

// File: rtl/irqv_resolver.sv
module irqv_resolver #(
  parameter int NUM_FIXED = 3,
  localparam int IDX_W = (NUM_FIXED > 1) ? $clog2(NUM_FIXED) : 1
) (
  input  logic                 trap_req,
  input  logic [NUM_FIXED-1:0] fixed_req,
  input  logic                 gen_req,
  input  logic                 gie,
  input  logic [NUM_FIXED-1:0] mask,
  output logic                 win_trap,
  output logic                 win_fixed,
  output logic                 win_gen,
  output logic [IDX_W-1:0]     win_idx
);
  logic [NUM_FIXED-1:0] eligible;
  logic                 any_fixed;

  for (genvar i = 0; i < NUM_FIXED; i++) begin : g_gate
    assign eligible[i] = fixed_req[i] & ~mask[i] & gie;
  end

  // Higher index overrides lower index
  always_comb begin
    win_idx = '0;
    for (int i = 0; i < NUM_FIXED; i++) begin
      if (eligible[i]) win_idx = IDX_W'(i);
    end
  end

  assign any_fixed = |eligible;
  assign win_trap  = trap_req;
  assign win_fixed = ~trap_req & any_fixed;
  assign win_gen   = ~trap_req & ~any_fixed & gen_req & gie;
endmodule

// File: rtl/irqv_enables.sv
module irqv_enables #(
  parameter int NUM_FIXED = 3
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 cmd_enable,
  input  logic                 cmd_disable,
  input  logic                 auto_clr,
  input  logic                 cmd_mask_wr,
  input  logic [NUM_FIXED-1:0] mask_data,
  output logic                 gie,
  output logic [NUM_FIXED-1:0] mask
);
  always_ff @(posedge clk) begin
    if (rst) begin
      gie  <= 1'b0;
      mask <= '1;
    end else begin
      if (auto_clr || cmd_disable) gie <= 1'b0;
      else if (cmd_enable)         gie <= 1'b1;
      if (cmd_mask_wr)             mask <= mask_data;
    end
  end
endmodule

// File: rtl/irqv_opdecode.sv
module irqv_opdecode
  import irqv_pkg::*;
#(
  parameter int ADDR_W       = 16,
  parameter int RESTART_STEP = 8
) (
  input  logic [OPC_W-1:0]  opcode,
  output logic              is_restart,
  output logic [ADDR_W-1:0] target
);
  logic [SLOT_W-1:0] slot;

  assign slot       = opcode[5:3];
  assign is_restart = (opcode[7:6] == 2'b11) && (opcode[2:0] == 3'b111);
  assign target     = ADDR_W'(slot) * ADDR_W'(RESTART_STEP);
endmodule

// File: rtl/irq_vector_ctrl.sv
module irq_vector_ctrl
  import irqv_pkg::*;
#(
  parameter int ADDR_W       = 16,
  parameter int NUM_FIXED    = 3,
  parameter int TRAP_VEC     = 'h24,
  parameter int FIXED_BASE   = 'h2C,
  parameter int FIXED_STEP   = 8,
  parameter int RESTART_STEP = 8
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 insn_done,
  input  logic                 trap_req,
  input  logic [NUM_FIXED-1:0] fixed_req,
  input  logic                 gen_req,
  input  logic                 cmd_enable,
  input  logic                 cmd_disable,
  input  logic                 cmd_mask_wr,
  input  logic [NUM_FIXED-1:0] mask_data,
  input  logic [7:0]           bus_data,
  input  logic                 bus_valid,
  output logic                 irq_ack,
  output logic                 push_pc,
  output logic [ADDR_W-1:0]    vec_addr,
  output logic                 opcode_fetch,
  output logic                 bad_opcode
);
  localparam int IDX_W = (NUM_FIXED > 1) ? $clog2(NUM_FIXED) : 1;

  irqv_state_e          state_q;
  logic                 busy;
  logic                 gie;
  logic [NUM_FIXED-1:0] mask;
  logic                 win_trap, win_fixed, win_gen;
  logic [IDX_W-1:0]     win_idx;
  logic                 auto_clr;
  logic                 is_restart;
  logic [ADDR_W-1:0]    restart_tgt;
  logic [ADDR_W-1:0]    fixed_vec [NUM_FIXED];

  for (genvar i = 0; i < NUM_FIXED; i++) begin : g_vec
    assign fixed_vec[i] = ADDR_W'(FIXED_BASE + i * FIXED_STEP);
  end

  assign busy     = (state_q == ST_FETCH);
  assign auto_clr = ~busy & insn_done & (win_fixed | win_gen);

  irqv_resolver #(.NUM_FIXED(NUM_FIXED)) u_res (
    .trap_req (trap_req),
    .fixed_req(fixed_req),
    .gen_req  (gen_req),
    .gie      (gie),
    .mask     (mask),
    .win_trap (win_trap),
    .win_fixed(win_fixed),
    .win_gen  (win_gen),
    .win_idx  (win_idx)
  );

  irqv_enables #(.NUM_FIXED(NUM_FIXED)) u_en (
    .clk        (clk),
    .rst        (rst),
    .cmd_enable (cmd_enable),
    .cmd_disable(cmd_disable),
    .auto_clr   (auto_clr),
    .cmd_mask_wr(cmd_mask_wr),
    .mask_data  (mask_data),
    .gie        (gie),
    .mask       (mask)
  );

  irqv_opdecode #(.ADDR_W(ADDR_W), .RESTART_STEP(RESTART_STEP)) u_dec (
    .opcode    (bus_data),
    .is_restart(is_restart),
    .target    (restart_tgt)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q      <= ST_IDLE;
      irq_ack      <= 1'b0;
      push_pc      <= 1'b0;
      opcode_fetch <= 1'b0;
      bad_opcode   <= 1'b0;
      vec_addr     <= '0;
    end else begin
      irq_ack      <= 1'b0;
      push_pc      <= 1'b0;
      opcode_fetch <= 1'b0;
      bad_opcode   <= 1'b0;
      case (state_q)
        ST_IDLE: begin
          if (insn_done) begin
            if (win_trap) begin
              irq_ack  <= 1'b1;
              push_pc  <= 1'b1;
              vec_addr <= ADDR_W'(TRAP_VEC);
            end else if (win_fixed) begin
              irq_ack  <= 1'b1;
              push_pc  <= 1'b1;
              vec_addr <= fixed_vec[win_idx];
            end else if (win_gen) begin
              opcode_fetch <= 1'b1;
              state_q      <= ST_FETCH;
            end
          end
        end
        ST_FETCH: begin
          if (bus_valid) begin
            state_q <= ST_IDLE;
            if (is_restart) begin
              irq_ack  <= 1'b1;
              push_pc  <= 1'b1;
              vec_addr <= restart_tgt;
            end else begin
              bad_opcode <= 1'b1;
            end
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/irqv_checker.sv
module irqv_checker #(
  parameter int ADDR_W     = 16,
  parameter int NUM_FIXED  = 3,
  parameter int TRAP_VEC   = 'h24,
  parameter int FIXED_BASE = 'h2C,
  parameter int FIXED_STEP = 8
) (
  input logic                 clk,
  input logic                 rst,
  input logic                 insn_done,
  input logic                 trap_req,
  input logic [NUM_FIXED-1:0] fixed_req,
  input logic                 bus_valid,
  input logic                 irq_ack,
  input logic                 push_pc,
  input logic [ADDR_W-1:0]    vec_addr,
  input logic                 opcode_fetch,
  input logic                 bad_opcode,
  input logic                 busy,
  input logic                 gie,
  input logic [NUM_FIXED-1:0] mask
);
  localparam logic [ADDR_W-1:0] TOP_VEC = ADDR_W'(FIXED_BASE + (NUM_FIXED - 1) * FIXED_STEP);

  // R3
  trap_taken_chk: assert property (@(posedge clk) disable iff (rst)
    insn_done && trap_req && !busy |=> irq_ack && vec_addr == ADDR_W'(TRAP_VEC));

  // R2
  top_fixed_chk: assert property (@(posedge clk) disable iff (rst)
    insn_done && !busy && !trap_req && fixed_req[NUM_FIXED-1] && gie && !mask[NUM_FIXED-1]
    |=> irq_ack && vec_addr == TOP_VEC);

  // R6
  bad_no_ack_chk: assert property (@(posedge clk) disable iff (rst)
    bad_opcode |-> !irq_ack && !push_pc && $past(busy) && $past(bus_valid));

  // R9
  no_take_waiting_chk: assert property (@(posedge clk) disable iff (rst)
    busy && !bus_valid |=> !irq_ack && !opcode_fetch);

  // R10
  ack_origin_chk: assert property (@(posedge clk) disable iff (rst)
    irq_ack |-> push_pc && ($past(insn_done) || $past(bus_valid)));

  // R11
  gen_clears_en_chk: assert property (@(posedge clk) disable iff (rst)
    opcode_fetch |-> !gie);

  // R11
  fixed_clears_en_chk: assert property (@(posedge clk) disable iff (rst)
    irq_ack && !$past(busy) && vec_addr != ADDR_W'(TRAP_VEC) |-> !gie);
endmodule

bind irq_vector_ctrl irqv_checker #(
  .ADDR_W    (ADDR_W),
  .NUM_FIXED (NUM_FIXED),
  .TRAP_VEC  (TRAP_VEC),
  .FIXED_BASE(FIXED_BASE),
  .FIXED_STEP(FIXED_STEP)
) u_chk (
  .clk         (clk),
  .rst         (rst),
  .insn_done   (insn_done),
  .trap_req    (trap_req),
  .fixed_req   (fixed_req),
  .bus_valid   (bus_valid),
  .irq_ack     (irq_ack),
  .push_pc     (push_pc),
  .vec_addr    (vec_addr),
  .opcode_fetch(opcode_fetch),
  .bad_opcode  (bad_opcode),
  .busy        (busy),
  .gie         (gie),
  .mask        (mask)
);

// File: tb/irq_vector_ctrl_tb.sv
module irq_vector_ctrl_tb;
  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       insn_done = 1'b0, trap_req = 1'b0, gen_req = 1'b0;
  logic [2:0] fixed_req = '0, mask_data = '0;
  logic       cmd_enable = 1'b0, cmd_disable = 1'b0, cmd_mask_wr = 1'b0;
  logic [7:0] bus_data = '0;
  logic       bus_valid = 1'b0;
  logic       irq_ack, push_pc, opcode_fetch, bad_opcode;
  logic [15:0] vec_addr;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  irq_vector_ctrl u_dut (
    .clk(clk), .rst(rst), .insn_done(insn_done), .trap_req(trap_req),
    .fixed_req(fixed_req), .gen_req(gen_req), .cmd_enable(cmd_enable),
    .cmd_disable(cmd_disable), .cmd_mask_wr(cmd_mask_wr), .mask_data(mask_data),
    .bus_data(bus_data), .bus_valid(bus_valid), .irq_ack(irq_ack),
    .push_pc(push_pc), .vec_addr(vec_addr), .opcode_fetch(opcode_fetch),
    .bad_opcode(bad_opcode)
  );

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // All tasks start and end at a falling edge.
  task automatic cmd(input logic en, input logic dis);
    cmd_enable = en; cmd_disable = dis;
    @(negedge clk);
    cmd_enable = 1'b0; cmd_disable = 1'b0;
  endtask

  task automatic set_mask(input logic [2:0] m);
    cmd_mask_wr = 1'b1; mask_data = m;
    @(negedge clk);
    cmd_mask_wr = 1'b0;
  endtask

  task automatic boundary(input logic t, input logic [2:0] f, input logic g);
    insn_done = 1'b1; trap_req = t; fixed_req = f; gen_req = g;
    @(negedge clk);
    insn_done = 1'b0; trap_req = 1'b0; fixed_req = '0; gen_req = 1'b0;
  endtask

  task automatic give_opcode(input logic [7:0] b);
    bus_valid = 1'b1; bus_data = b;
    @(negedge clk);
    bus_valid = 1'b0;
  endtask

  task automatic expect_ack(input string tag, input logic [15:0] v);
    check({tag, " ack"}, irq_ack, 1);
    check({tag, " push"}, push_pc, 1);
    check({tag, " vec"}, vec_addr, v);
  endtask

  task automatic expect_none(input string tag);
    check({tag, " no ack"}, irq_ack, 0);
    check({tag, " no fetch"}, opcode_fetch, 0);
  endtask

  task automatic t_reset;
    check("R1 ack", irq_ack, 0);
    check("R1 push", push_pc, 0);
    check("R1 fetch", opcode_fetch, 0);
    check("R1 bad", bad_opcode, 0);
    check("R1 vec", vec_addr, 0);
    boundary(1'b0, 3'b111, 1'b1);
    expect_none("R1 masked after reset");
  endtask

  task automatic t_trap;
    boundary(1'b1, 3'b000, 1'b0);
    expect_ack("R3 trap with enable clear", 16'h0024);
    @(negedge clk);
    check("R10 ack pulse ends", irq_ack, 0);
    check("R10 push pulse ends", push_pc, 0);
  endtask

  task automatic t_fixed;
    set_mask(3'b000);
    for (int i = 0; i < 3; i++) begin
      cmd(1'b1, 1'b0);
      boundary(1'b0, 3'(1 << i), 1'b0);
      expect_ack("R4 fixed vector", 16'(16'h002C + 8 * i));
    end
  endtask

  task automatic t_autoclr;
    cmd(1'b1, 1'b0);
    boundary(1'b0, 3'b001, 1'b0);
    expect_ack("R11 first take", 16'h002C);
    boundary(1'b0, 3'b001, 1'b0);
    expect_none("R11 enable cleared");
    // trap leaves enable intact
    cmd(1'b1, 1'b0);
    boundary(1'b1, 3'b000, 1'b0);
    expect_ack("R11 trap", 16'h0024);
    boundary(1'b0, 3'b001, 1'b0);
    expect_ack("R11 enable kept after trap", 16'h002C);
    // auto clear beats same-cycle enable
    cmd_enable = 1'b1;
    cmd(1'b1, 1'b0);
    cmd_enable = 1'b1;
    boundary(1'b0, 3'b010, 1'b0);
    cmd_enable = 1'b0;
    expect_ack("R11 take with enable", 16'h0034);
    boundary(1'b0, 3'b010, 1'b0);
    expect_none("R11 clear wins over enable");
  endtask

  task automatic t_priority;
    cmd(1'b1, 1'b0);
    boundary(1'b1, 3'b111, 1'b1);
    expect_ack("R2 trap over all", 16'h0024);
    boundary(1'b0, 3'b111, 1'b1);
    expect_ack("R2 top fixed", 16'h003C);
    cmd(1'b1, 1'b0);
    boundary(1'b0, 3'b011, 1'b1);
    expect_ack("R2 middle fixed", 16'h0034);
    cmd(1'b1, 1'b0);
    boundary(1'b0, 3'b001, 1'b1);
    expect_ack("R2 low fixed over general", 16'h002C);
    cmd(1'b1, 1'b0);
    boundary(1'b0, 3'b000, 1'b1);
    check("R2 general fetch", opcode_fetch, 1);
    check("R2 general no ack yet", irq_ack, 0);
    give_opcode(8'hFF);
    expect_ack("R5 slot 7 via priority", 16'h0038);
  endtask

  task automatic t_mask;
    cmd(1'b1, 1'b0);
    set_mask(3'b100);
    boundary(1'b0, 3'b111, 1'b0);
    expect_ack("R8 top masked", 16'h0034);
    set_mask(3'b111);
    cmd(1'b1, 1'b0);
    boundary(1'b0, 3'b111, 1'b0);
    expect_none("R8 all masked");
    boundary(1'b0, 3'b111, 1'b1);
    check("R8 general unaffected by mask", opcode_fetch, 1);
    give_opcode(8'hC7);
    expect_ack("R8 general slot 0", 16'h0000);
    set_mask(3'b000);
  endtask

  task automatic t_disable;
    cmd(1'b1, 1'b0);
    cmd(1'b0, 1'b1);
    boundary(1'b0, 3'b001, 1'b1);
    expect_none("R7 disabled");
    cmd(1'b1, 1'b0);
    cmd(1'b1, 1'b1);
    boundary(1'b0, 3'b001, 1'b1);
    expect_none("R7 disable wins");
    cmd(1'b1, 1'b0);
    boundary(1'b0, 3'b001, 1'b0);
    expect_ack("R7 enable restores", 16'h002C);
  endtask

  task automatic t_boundary;
    cmd(1'b1, 1'b0);
    trap_req = 1'b1; fixed_req = 3'b111;
    repeat (3) @(negedge clk);
    expect_none("R9 no boundary");
    trap_req = 1'b0; fixed_req = '0;
    boundary(1'b0, 3'b100, 1'b0);
    expect_ack("R9 taken at boundary", 16'h003C);
  endtask

  task automatic t_general(input int n);
    cmd(1'b1, 1'b0);
    boundary(1'b0, 3'b000, 1'b1);
    check("R5 fetch raised", opcode_fetch, 1);
    boundary(1'b1, 3'b111, 1'b1);
    check("R5 fetch pulse ends", opcode_fetch, 0);
    expect_none("R9 waiting for opcode");
    give_opcode(8'hC7 | 8'(n << 3));
    expect_ack("R5 restart vector", 16'(n * 8));
    check("R6 no bad on restart", bad_opcode, 0);
  endtask

  task automatic t_bad(input logic [7:0] b);
    cmd(1'b1, 1'b0);
    boundary(1'b0, 3'b000, 1'b1);
    check("R6 fetch raised", opcode_fetch, 1);
    give_opcode(b);
    check("R6 bad flag", bad_opcode, 1);
    check("R6 no ack", irq_ack, 0);
    check("R6 no push", push_pc, 0);
    @(negedge clk);
    check("R6 bad pulse ends", bad_opcode, 0);
    boundary(1'b0, 3'b001, 1'b0);
    expect_none("R11 general take cleared enable");
  endtask

  initial begin
    @(negedge clk);
    @(negedge clk);
    rst = 1'b0;
    t_reset();
    t_trap();
    t_fixed();
    t_autoclr();
    t_priority();
    t_mask();
    t_disable();
    t_boundary();
    t_general(0);
    t_general(5);
    t_general(7);
    t_bad(8'h3E);
    t_bad(8'hC6);
    if (!done) begin
      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      checks++;
      errors++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule